// File: doc/BRIEF.md
# Adaptive Receive Equalizer Gain and Zero Controller

This block keeps the two codes that steer an analog receive equalizer: a low-frequency gain level and a zero-frequency position. An external pattern and transition-timing analyzer sends single-cycle raise and lower decisions for the gain. The block turns them into saturating code updates. A 4-bit mode word picks how the codes respond:
- flat maximum gain;
- full adaptation, where a gain that is stuck at a limit moves the zero instead, with the zero moving in either the normal or the inverted direction;
- freeze;
- reset to half scale;
- partial adaptation with the zero pinned to one of eight fixed positions.

Two override enables force either output code from a register value for as long as they are set. While an output is overridden, the internal code underneath it keeps adapting. Every state change lands one clock after the decision or mode that caused it. The override paths are combinational.

The decision inputs are plain single-cycle pulses. They have no valid/ready handshake: the analyzer never waits, and the block consumes one decision per cycle with no back-pressure. A raise and a lower decision in the same cycle cancel each other.

Top module: `eq_adapt_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the gain code is 0x8000 (half of 16-bit scale) and the zero code is 16, until the first state update.
- R2: With mode word 0000 the gain output becomes 0xFFFF one cycle later and stays there. Raise and lower decisions then change neither code, and the zero code is held.
- R3: In modes 0001, 0010 and 1xxx, a lone raise decision increments the gain by one and a lone lower decision decrements it by one, visible on the next cycle. The gain saturates at 0 and 0xFFFF.
- R4: In mode 0001, a raise while the gain is 0xFFFF increments the zero code, and a lower while the gain is 0 decrements it. In both cases the gain is unchanged.
- R5: In mode 0010 the zero moves the opposite way: a raise at gain 0xFFFF decrements it, and a lower at gain 0 increments it.
- R6: The zero code saturates at 0 and 31. In partially adaptive mode a decision at a gain limit leaves both codes unchanged.
- R7: Mode 0011 keeps both codes unchanged whatever the decisions are.
- R8: Modes 0100 to 0111 load gain 0x8000 and zero 16 on the next cycle.
- R9: In mode 1xxx, the zero code becomes 28 − 4·(mode[2:0]) on the next cycle. This gives eight positions from 28 (highest frequency) down to 0.
- R10: A raise and a lower decision in the same cycle change neither code in any adaptive mode.
- R11: While a gain or zero override enable is 1, that output equals the 16-bit or 5-bit override value in the same cycle. The internal code keeps adapting and appears on the output again once the override is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Operating mode word |
| inc_i | input | 1 | Raise-gain decision pulse |
| dec_i | input | 1 | Lower-gain decision pulse |
| lvl_ovrd_en_i | input | 1 | Force gain output from lvl_ovrd_i |
| lvl_ovrd_i | input | 16 | Gain override value |
| zero_ovrd_en_i | input | 1 | Force zero output from zero_ovrd_i |
| zero_ovrd_i | input | 5 | Zero override value |
| lvl_o | output | 16 | Gain level code to the equalizer |
| zero_o | output | 5 | Zero-frequency code to the equalizer |

## Verification
The properties assume that the override enables are low in both cycles they compare. They also assume that the mode word they inspect was sampled one clock earlier, with reset already released. The stimulus therefore changes the mode and the decision lines only on the falling edge, where they are sampled once per rising edge. The random phase keeps overrides off most of the time, so the state-tracking properties are active for long stretches. A directed descent of the full gain range, together with the flat-gain mode that loads the maximum, drives the gain to both limits. This is what exercises zero spill and saturation.

// File: rtl/eq_adapt_pkg.sv
package eq_adapt_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [2:0] {
    EQM_OFF,
    EQM_FULL_NRM,
    EQM_FULL_INV,
    EQM_HOLD,
    EQM_INIT,
    EQM_PART
  } eq_mode_e;

  function automatic eq_mode_e eq_decode(input logic [MODE_W-1:0] w);
    if (w[3])      return EQM_PART;
    else if (w[2]) return EQM_INIT;
    else begin
      case (w[1:0])
        2'b00:   return EQM_OFF;
        2'b01:   return EQM_FULL_NRM;
        2'b10:   return EQM_FULL_INV;
        default: return EQM_HOLD;
      endcase
    end
  endfunction
endpackage

// File: rtl/eq_mode_dec.sv
module eq_mode_dec
  import eq_adapt_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              off_o,
  output logic              init_o,
  output logic              adapt_o,
  output logic              full_o,
  output logic              invert_o,
  output logic              part_o,
  output logic [2:0]        fix_idx_o
);
  eq_mode_e m;

  always_comb begin
    m         = eq_decode(mode_i);
    off_o     = (m == EQM_OFF);
    init_o    = (m == EQM_INIT);
    full_o    = (m == EQM_FULL_NRM) || (m == EQM_FULL_INV);
    invert_o  = (m == EQM_FULL_INV);
    part_o    = (m == EQM_PART);
    adapt_o   = full_o || part_o;
    fix_idx_o = mode_i[2:0];
  end
endmodule

// File: rtl/eq_gain_ctr.sv
module eq_gain_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_max,
  input  logic         load_mid,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] q,
  output logic         at_max,
  output logic         at_min
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  assign at_max = &q;
  assign at_min = ~|q;

  always_ff @(posedge clk) begin
    if (!rst_n)                q <= MID;
    else if (load_max)         q <= '1;
    else if (load_mid)         q <= MID;
    else if (up && !at_max)    q <= q + W'(1);
    else if (dn && !at_min)    q <= q - W'(1);
  end
endmodule

// File: rtl/eq_zero_ctr.sv
module eq_zero_ctr #(
  parameter int W    = 5,
  parameter int TOP  = 28,
  parameter int STEP = 4,
  parameter int NPOS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_mid,
  input  logic                    load_fix,
  input  logic [$clog2(NPOS)-1:0] fix_idx,
  input  logic                    up,
  input  logic                    dn,
  output logic [W-1:0]            q
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0] fix_tab [NPOS];

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    assign fix_tab[i] = W'(TOP - STEP * i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                q <= MID;
    else if (load_mid)         q <= MID;
    else if (load_fix)         q <= fix_tab[fix_idx];
    else if (up && !(&q))      q <= q + W'(1);
    else if (dn && |q)         q <= q - W'(1);
  end
endmodule

// File: rtl/eq_adapt_ctrl.sv
module eq_adapt_ctrl
  import eq_adapt_pkg::*;
#(
  parameter int LVL_W     = 16,
  parameter int ZW        = 5,
  parameter int ZERO_TOP  = 28,
  parameter int ZERO_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              lvl_ovrd_en_i,
  input  logic [LVL_W-1:0]  lvl_ovrd_i,
  input  logic              zero_ovrd_en_i,
  input  logic [ZW-1:0]     zero_ovrd_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [ZW-1:0]     zero_o
);
  localparam int NPOS = 8;

  logic off, init, adapt, full, invert, part;
  logic [2:0] fix_idx;
  logic up_req, dn_req, spill_up, spill_dn, z_up, z_dn;
  logic g_at_max, g_at_min;
  logic [LVL_W-1:0] gain_q;
  logic [ZW-1:0]    zero_q;

  eq_mode_dec u_dec (
    .mode_i    (mode_i),
    .off_o     (off),
    .init_o    (init),
    .adapt_o   (adapt),
    .full_o    (full),
    .invert_o  (invert),
    .part_o    (part),
    .fix_idx_o (fix_idx)
  );

  // opposing decisions cancel
  assign up_req = adapt & inc_i & ~dec_i;
  assign dn_req = adapt & dec_i & ~inc_i;

  // gain stuck at a limit spills into the zero in full modes only
  assign spill_up = full & up_req & g_at_max;
  assign spill_dn = full & dn_req & g_at_min;
  assign z_up     = invert ? spill_dn : spill_up;
  assign z_dn     = invert ? spill_up : spill_dn;

  eq_gain_ctr #(.W(LVL_W)) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_max (off),
    .load_mid (init),
    .up       (up_req),
    .dn       (dn_req),
    .q        (gain_q),
    .at_max   (g_at_max),
    .at_min   (g_at_min)
  );

  eq_zero_ctr #(.W(ZW), .TOP(ZERO_TOP), .STEP(ZERO_STEP), .NPOS(NPOS)) u_zero (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_mid (init),
    .load_fix (part),
    .fix_idx  (fix_idx),
    .up       (z_up),
    .dn       (z_dn),
    .q        (zero_q)
  );

  assign lvl_o  = lvl_ovrd_en_i  ? lvl_ovrd_i  : gain_q;
  assign zero_o = zero_ovrd_en_i ? zero_ovrd_i : zero_q;
endmodule

// File: rtl/eq_adapt_ctrl_chk.sv
module eq_adapt_ctrl_chk #(
  parameter int LVL_W     = 16,
  parameter int ZW        = 5,
  parameter int ZERO_TOP  = 28,
  parameter int ZERO_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode_i,
  input logic             inc_i,
  input logic             dec_i,
  input logic             lvl_ovrd_en_i,
  input logic [LVL_W-1:0] lvl_ovrd_i,
  input logic             zero_ovrd_en_i,
  input logic [ZW-1:0]    zero_ovrd_i,
  input logic [LVL_W-1:0] lvl_o,
  input logic [ZW-1:0]    zero_o
);
  logic adapt_m;
  logic free_q;
  assign adapt_m = (mode_i == 4'b0001) || (mode_i == 4'b0010) || mode_i[3];
  assign free_q  = !lvl_ovrd_en_i && !zero_ovrd_en_i;

  AST_OFF_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) == 4'b0000 && !lvl_ovrd_en_i) |-> (&lvl_o)); // R2

  AST_GAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(adapt_m) && !lvl_ovrd_en_i && !$past(lvl_ovrd_en_i)) |->
      (lvl_o == $past(lvl_o) || lvl_o == $past(lvl_o) + LVL_W'(1)
       || lvl_o == $past(lvl_o) - LVL_W'(1))); // R3

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) == 4'b0011 && free_q && $past(free_q)) |->
      ($stable(lvl_o) && $stable(zero_o))); // R7

  AST_INIT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i[3:2]) == 2'b01 && free_q) |->
      (lvl_o == (LVL_W'(1) << (LVL_W - 1)) && zero_o == (ZW'(1) << (ZW - 1)))); // R8

  AST_PART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i[3]) && !zero_ovrd_en_i) |->
      (zero_o == ZW'(ZERO_TOP - ZERO_STEP * int'($past(mode_i[2:0]))))); // R9

  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(adapt_m) && !$past(mode_i[3]) && $past(inc_i) && $past(dec_i)
     && free_q && $past(free_q)) |-> ($stable(lvl_o) && $stable(zero_o))); // R10

  AST_OVRD_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_ovrd_en_i |-> (lvl_o == lvl_ovrd_i)); // R11

  AST_OVRD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ovrd_en_i |-> (zero_o == zero_ovrd_i)); // R11
endmodule

bind eq_adapt_ctrl eq_adapt_ctrl_chk #(
  .LVL_W(LVL_W), .ZW(ZW), .ZERO_TOP(ZERO_TOP), .ZERO_STEP(ZERO_STEP)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_i         (mode_i),
  .inc_i          (inc_i),
  .dec_i          (dec_i),
  .lvl_ovrd_en_i  (lvl_ovrd_en_i),
  .lvl_ovrd_i     (lvl_ovrd_i),
  .zero_ovrd_en_i (zero_ovrd_en_i),
  .zero_ovrd_i    (zero_ovrd_i),
  .lvl_o          (lvl_o),
  .zero_o         (zero_o)
);

// File: tb/test_eq_adapt_ctrl.sv
module test_eq_adapt_ctrl;
  localparam int GMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'b0011;
  logic        inc = 1'b0, dec = 1'b0;
  logic        lovr_en = 1'b0, zovr_en = 1'b0;
  logic [15:0] lovr = '0;
  logic [4:0]  zovr = '0;
  logic [15:0] lvl;
  logic [4:0]  zero;

  int n_chk = 0, n_bad = 0;
  int mg = 32768, mz = 16;

  always #2.5 clk = ~clk;

  eq_adapt_ctrl i_eq_adapt_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .inc_i(inc), .dec_i(dec),
    .lvl_ovrd_en_i(lovr_en), .lvl_ovrd_i(lovr),
    .zero_ovrd_en_i(zovr_en), .zero_ovrd_i(zovr),
    .lvl_o(lvl), .zero_o(zero)
  );

  function automatic int clampz(input int v);
    if (v < 0) return 0;
    if (v > 31) return 31;
    return v;
  endfunction

  // reference model of one clock edge, derived from the requirements
  function automatic void model_step(input logic [3:0] m, input logic i, input logic d);
    bit up, dn, inv;
    int zd;
    up = i && !d; dn = d && !i; zd = 0;
    if (m == 4'b0000) mg = GMAX;
    else if (m == 4'b0011) begin end
    else if (m[3:2] == 2'b01) begin mg = 32768; mz = 16; end
    else if (m[3]) begin
      mz = 28 - 4 * int'(m[2:0]);
      if (up && mg < GMAX) mg++;
      else if (dn && mg > 0) mg--;
    end else begin
      inv = (m == 4'b0010);
      if (up) begin
        if (mg < GMAX) mg++; else zd = inv ? -1 : 1;
      end else if (dn) begin
        if (mg > 0) mg--; else zd = inv ? 1 : -1;
      end
      mz = clampz(mz + zd);
    end
  endfunction

  function automatic string tag_for(input logic [3:0] m, input logic i, input logic d);
    if (lovr_en || zovr_en) return "R11";
    if (m == 4'b0000) return "R2";
    if (m == 4'b0011) return "R7";
    if (m[3:2] == 2'b01) return "R8";
    if (i && d) return "R10";
    if (m[3]) return "R9";
    return "R3";
  endfunction

  task automatic check(input string tag);
    int el, ez;
    el = lovr_en ? int'(lovr) : mg;
    ez = zovr_en ? int'(zovr) : mz;
    n_chk++;
    if (int'(lvl) != el || int'(zero) != ez) begin
      n_bad++;
      $display("FAIL %s lvl=%h exp %h zero=%0d exp %0d", tag, lvl, el[15:0], zero, ez);
    end
  endtask

  task automatic cyc(input logic [3:0] m, input logic i, input logic d, input string tag);
    mode = m; inc = i; dec = d;
    @(posedge clk);
    model_step(m, i, d);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    cyc(4'b0011, 1'b1, 1'b0, "R1");

    // flat gain, decisions ignored
    cyc(4'b0000, 1'b0, 1'b1, "R2");
    cyc(4'b0000, 1'b0, 1'b1, "R2");
    cyc(4'b0000, 1'b1, 1'b0, "R2");

    // spill normal: raise at max moves zero up, saturating at 31
    for (int k = 0; k < 18; k++) cyc(4'b0001, 1'b1, 1'b0, k < 15 ? "R4" : "R6");
    // inverted: raise at max moves zero down
    for (int k = 0; k < 3; k++) cyc(4'b0010, 1'b1, 1'b0, "R5");
    cyc(4'b0001, 1'b1, 1'b1, "R10");
    cyc(4'b0011, 1'b0, 1'b1, "R7");
    cyc(4'b0011, 1'b1, 1'b0, "R7");

    // descend to gain 0
    for (int k = 0; k < 65535; k++) cyc(4'b0001, 1'b0, 1'b1, "R3");
    for (int k = 0; k < 4; k++) cyc(4'b0001, 1'b0, 1'b1, "R4");
    for (int k = 0; k < 3; k++) cyc(4'b0010, 1'b0, 1'b1, "R5");
    for (int k = 0; k < 40; k++) cyc(4'b0001, 1'b0, 1'b1, "R6");
    cyc(4'b0001, 1'b1, 1'b1, "R10");

    // partial positions; lower at gain 0 changes nothing
    for (int p = 8; p < 16; p++) begin
      cyc(4'(p), 1'b0, 1'b1, "R6");
      cyc(4'(p), 1'b0, 1'b0, "R9");
    end
    cyc(4'b1010, 1'b1, 1'b0, "R3");
    cyc(4'b0101, 1'b0, 1'b0, "R8");
    cyc(4'b0111, 1'b1, 1'b0, "R8");

    // overrides, state adapts underneath
    lovr_en = 1'b1; lovr = 16'h1234; zovr_en = 1'b1; zovr = 5'd3;
    for (int k = 0; k < 5; k++) cyc(4'b0001, 1'b1, 1'b0, "R11");
    lovr_en = 1'b0; zovr_en = 1'b0;
    cyc(4'b0011, 1'b0, 1'b0, "R11");

    // constrained random
    begin
      logic [3:0] rm;
      rm = 4'b0001;
      for (int k = 0; k < 6000; k++) begin
        logic ri, rd;
        if ($urandom_range(63) == 0) rm = 4'($urandom_range(15));
        ri = ($urandom_range(2) == 0);
        rd = ($urandom_range(2) == 0);
        lovr_en = ($urandom_range(7) == 0);
        zovr_en = ($urandom_range(7) == 0);
        lovr = 16'($urandom);
        zovr = 5'($urandom);
        cyc(rm, ri, rd, tag_for(rm, ri, rd));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule